// File: doc/BRIEF.md
# Status Flag Register and Branch Condition Evaluator

This block sits beside an n-bit arithmetic unit and turns its raw outputs into four status flags: carry (C), sign (S), zero (Z) and overflow (V). It reads the result word, the carry into the most significant bit and the carry out of it. It loads the flags into a single register on a clock edge only while the update enable is high. Compare and test operations use the same path, so they change the flags and nothing else.

A 5-bit condition code selects one of eighteen tests on the stored flags. A combinational decision output says whether a branch is taken. Some tests look at one flag alone. The others read the flags as the outcome of an earlier subtraction A-B, done as A plus the inverted B plus one, and give unsigned or signed ordering. Codes outside the eighteen defined ones never branch.

Top module: `cond_flag_unit`

## Requirements
- R1: While reset is asserted, and after it is released until the first update, `flags_o` reads 0000 (bit 3 = C, bit 2 = S, bit 1 = Z, bit 0 = V). An update requested during reset is ignored.
- R2: On a clock edge with `upd_en_i` high, C (bit 3) takes the value of `cout_top_i`.
- R3: On a clock edge with `upd_en_i` high, S (bit 2) takes the value of the result's most significant bit.
- R4: On a clock edge with `upd_en_i` high, Z (bit 1) is 1 exactly when every bit of the result is 0.
- R5: On a clock edge with `upd_en_i` high, V (bit 0) takes the XOR of `cin_top_i` and `cout_top_i`.
- R6: On a clock edge with `upd_en_i` low, all four flags keep their values, whatever the result and carry inputs are.
- R7: Single-flag codes: 0 takes on Z=1, 1 on Z=0, 2 on C=1, 3 on C=0, 4 on S=0, 5 on S=1, 6 on V=1, 7 on V=0.
- R8: Unsigned codes after A-B: 8 (higher) takes on C=1 and Z=0, 9 (higher or same) on C=1, 10 (lower) on C=0, 11 (lower or same) on C=0 or Z=1.
- R9: Equality codes: 12 (equal) takes on Z=1, 13 (not equal) on Z=0.
- R10: Signed codes after A-B: 14 (greater) takes when S XOR V is 0 and Z=0, 15 (greater or equal) when S XOR V is 0, 16 (less) when S XOR V is 1, 17 (less or equal) when S XOR V is 1 or Z=1.
- R11: Codes 18 through 31 always drive `take_o` low.
- R12: `take_o` follows the flags held at that moment and the current code with no clock latency. In a cycle that also loads new flags, the decision uses the old flags until the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| res_i | input | DATA_W | Result word from the arithmetic unit |
| cin_top_i | input | 1 | Carry into the most significant bit |
| cout_top_i | input | 1 | Carry out of the most significant bit |
| upd_en_i | input | 1 | Load the flag register on this edge |
| cond_i | input | 5 | Branch condition code |
| flags_o | output | 4 | Stored flags {C, S, Z, V} |
| take_o | output | 1 | Branch decision for `cond_i` on the stored flags |

## Verification
A flag load and a branch decision can fall in the same cycle: the condition being tested reads the register that the same edge is about to overwrite. The bench drives a new result with the update enable high, and in that same cycle it sets a condition code. Before the edge it compares `take_o` with a decision computed from the flags it modelled for the previous load. After the edge it checks the new flags bit by bit. Random subtractions, including operand pairs that are equal or differ by one, make the decision change across such loads for both signed and unsigned codes.

// File: rtl/cfu_pkg.sv
package cfu_pkg;
  localparam int COND_W = 5;

  typedef enum logic [COND_W-1:0] {
    CC_ZSET  = 5'd0,
    CC_ZCLR  = 5'd1,
    CC_CSET  = 5'd2,
    CC_CCLR  = 5'd3,
    CC_POS   = 5'd4,
    CC_NEG   = 5'd5,
    CC_VSET  = 5'd6,
    CC_VCLR  = 5'd7,
    CC_UGT   = 5'd8,
    CC_UGE   = 5'd9,
    CC_ULT   = 5'd10,
    CC_ULE   = 5'd11,
    CC_EQ    = 5'd12,
    CC_NE    = 5'd13,
    CC_SGT   = 5'd14,
    CC_SGE   = 5'd15,
    CC_SLT   = 5'd16,
    CC_SLE   = 5'd17
  } cond_e;

  typedef struct packed {
    logic c;
    logic s;
    logic z;
    logic v;
  } flags_t;
endpackage

// File: rtl/cfu_rst_sync.sv
module cfu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cfu_flag_gen.sv
module cfu_flag_gen
  import cfu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] res_i,
  input  logic              cin_top_i,
  input  logic              cout_top_i,
  output flags_t            flags_o
);
  localparam int MSB = DATA_W - 1;

  always_comb begin
    flags_o.c = cout_top_i;
    flags_o.s = res_i[MSB];
    flags_o.z = ~(|res_i);
    flags_o.v = cin_top_i ^ cout_top_i;
  end
endmodule

// File: rtl/cfu_flag_reg.sv
module cfu_flag_reg
  import cfu_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   upd_en_i,
  input  flags_t flags_d_i,
  output flags_t flags_q_o
);
  flags_t flags_q;
  flags_t flags_nxt;

  always_comb begin
    flags_nxt = flags_q;
    if (upd_en_i) flags_nxt = flags_d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_nxt;
  end

  assign flags_q_o = flags_q;
endmodule

// File: rtl/cfu_cond_eval.sv
module cfu_cond_eval
  import cfu_pkg::*;
(
  input  flags_t            flags_i,
  input  logic [COND_W-1:0] cond_i,
  output logic              take_o
);
  logic lt_s;

  always_comb begin
    lt_s = flags_i.s ^ flags_i.v;
    unique case (cond_i)
      CC_ZSET: take_o = flags_i.z;
      CC_ZCLR: take_o = ~flags_i.z;
      CC_CSET: take_o = flags_i.c;
      CC_CCLR: take_o = ~flags_i.c;
      CC_POS:  take_o = ~flags_i.s;
      CC_NEG:  take_o = flags_i.s;
      CC_VSET: take_o = flags_i.v;
      CC_VCLR: take_o = ~flags_i.v;
      CC_UGT:  take_o = flags_i.c & ~flags_i.z;
      CC_UGE:  take_o = flags_i.c;
      CC_ULT:  take_o = ~flags_i.c;
      CC_ULE:  take_o = ~flags_i.c | flags_i.z;
      CC_EQ:   take_o = flags_i.z;
      CC_NE:   take_o = ~flags_i.z;
      CC_SGT:  take_o = ~lt_s & ~flags_i.z;
      CC_SGE:  take_o = ~lt_s;
      CC_SLT:  take_o = lt_s;
      CC_SLE:  take_o = lt_s | flags_i.z;
      default: take_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cond_flag_unit.sv
module cond_flag_unit
  import cfu_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] res_i,
  input  logic              cin_top_i,
  input  logic              cout_top_i,
  input  logic              upd_en_i,
  input  logic [4:0]        cond_i,
  output logic [3:0]        flags_o,
  output logic              take_o
);
  logic   rst_sync_n;
  flags_t flags_new;
  flags_t flags_cur;

  cfu_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cfu_flag_gen #(.DATA_W(DATA_W)) u_flag_gen (
    .res_i      (res_i),
    .cin_top_i  (cin_top_i),
    .cout_top_i (cout_top_i),
    .flags_o    (flags_new)
  );

  cfu_flag_reg u_flag_reg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .upd_en_i  (upd_en_i),
    .flags_d_i (flags_new),
    .flags_q_o (flags_cur)
  );

  cfu_cond_eval u_cond_eval (
    .flags_i (flags_cur),
    .cond_i  (cond_i),
    .take_o  (take_o)
  );

  assign flags_o = flags_cur;
endmodule

// File: rtl/cfu_checker.sv
module cfu_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] res_i,
  input logic              cin_top_i,
  input logic              cout_top_i,
  input logic              upd_en_i,
  input logic [4:0]        cond_i,
  input logic [3:0]        flags_o,
  input logic              take_o
);
  always @(posedge clk) begin
    if (!rst_n) a_r1_reset_clear: assert (flags_o == 4'b0000);
  end

  a_r2_carry_load: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en_i |=> flags_o[3] == $past(cout_top_i));

  a_r3_sign_load: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en_i |=> flags_o[2] == $past(res_i[DATA_W-1]));

  a_r4_zero_load: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en_i |=> flags_o[1] == ($past(res_i) == '0));

  a_r5_ovf_load: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en_i |=> flags_o[0] == ($past(cin_top_i) != $past(cout_top_i)));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en_i |=> $stable(flags_o));

  a_r9_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_i == 5'd12) |-> (take_o == flags_o[1]));

  a_r10_signed_less: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_i == 5'd16) |-> (take_o == (flags_o[2] != flags_o[0])));

  a_r11_unused_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_i >= 5'd18) |-> !take_o);
endmodule

bind cond_flag_unit cfu_checker #(.DATA_W(DATA_W)) u_cfu_checker (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .res_i      (res_i),
  .cin_top_i  (cin_top_i),
  .cout_top_i (cout_top_i),
  .upd_en_i   (upd_en_i),
  .cond_i     (cond_i),
  .flags_o    (flags_o),
  .take_o     (take_o)
);

// File: tb/cond_flag_unit_bench.sv
module cond_flag_unit_bench;
  localparam int DW = 16;

  logic          clk;
  logic          rst_n;
  logic [DW-1:0] res;
  logic          cin;
  logic          cout;
  logic          upd;
  logic [4:0]    cond;
  logic [3:0]    flags;
  logic          take;

  int   n_chk;
  int   n_bad;
  logic [3:0] exp_f;
  logic       last_upd;
  bit         done;

  cond_flag_unit #(.DATA_W(DW)) u_cond_flag_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .res_i      (res),
    .cin_top_i  (cin),
    .cout_top_i (cout),
    .upd_en_i   (upd),
    .cond_i     (cond),
    .flags_o    (flags),
    .take_o     (take)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic exp_take(input logic [3:0] f, input logic [4:0] cc);
    logic c, s, z, v;
    {c, s, z, v} = f;
    case (cc)
      5'd0:  return z;
      5'd1:  return !z;
      5'd2:  return c;
      5'd3:  return !c;
      5'd4:  return !s;
      5'd5:  return s;
      5'd6:  return v;
      5'd7:  return !v;
      5'd8:  return c && !z;
      5'd9:  return c;
      5'd10: return !c;
      5'd11: return !c || z;
      5'd12: return z;
      5'd13: return !z;
      5'd14: return (s == v) && !z;
      5'd15: return s == v;
      5'd16: return s != v;
      5'd17: return (s != v) || z;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(input logic [4:0] cc);
    if (cc < 5'd8)  return "R7";
    if (cc < 5'd12) return "R8";
    if (cc < 5'd14) return "R9";
    if (cc < 5'd18) return "R10";
    return "R11";
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_flags();
    if (last_upd) begin
      chk("R2", {31'd0, flags[3]}, {31'd0, exp_f[3]});
      chk("R3", {31'd0, flags[2]}, {31'd0, exp_f[2]});
      chk("R4", {31'd0, flags[1]}, {31'd0, exp_f[1]});
      chk("R5", {31'd0, flags[0]}, {31'd0, exp_f[0]});
    end else begin
      chk("R6", {28'd0, flags}, {28'd0, exp_f});
    end
  endtask

  task automatic step(input logic [DW-1:0] r, input logic ci, input logic co,
                      input logic up, input logic [4:0] cc, input string tg);
    @(negedge clk);
    res = r; cin = ci; cout = co; upd = up; cond = cc;
    #1;
    check_flags();
    chk(tg, {31'd0, take}, {31'd0, exp_take(exp_f, cc)});
    @(posedge clk);
    if (up) exp_f = {co, r[DW-1], (r == '0), ci ^ co};
    last_upd = up;
  endtask

  task automatic sub_step(input logic [DW-1:0] a, input logic [DW-1:0] b,
                          input logic [4:0] cc);
    logic [DW:0]   full;
    logic [DW-1:0] low;
    full = {1'b0, a} + {1'b0, ~b} + 1'b1;
    low  = {1'b0, a[DW-2:0]} + {1'b0, ~b[DW-2:0]} + 1'b1;
    step(full[DW-1:0], low[DW-1], full[DW], 1'b1, cc, tag_of(cc));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    exp_f = 4'b0000; last_upd = 1'b0;
    rst_n = 1'b0; res = '0; cin = 1'b0; cout = 1'b0; upd = 1'b0; cond = 5'd0;
    void'($urandom(32'd20240611));

    // R1: reset state, and a load request during reset is ignored
    repeat (2) @(negedge clk);
    chk("R1", {28'd0, flags}, 32'd0);
    res = 16'h8000; cin = 1'b1; cout = 1'b0; upd = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", {28'd0, flags}, 32'd0);
    upd = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", {28'd0, flags}, 32'd0);

    // directed corners: zero with carry, sign with overflow
    step(16'h0000, 1'b1, 1'b1, 1'b1, 5'd0, "R7");
    step(16'h1234, 1'b0, 1'b0, 1'b0, 5'd0, "R7");  // flags Z,C loaded; hold next
    step(16'h8000, 1'b1, 1'b0, 1'b1, 5'd12, "R9");
    step(16'h0001, 1'b0, 1'b1, 1'b0, 5'd5, "R7");
    step(16'hFFFF, 1'b1, 1'b1, 1'b0, 5'd6, "R7");
    step(16'h0000, 1'b0, 1'b0, 1'b0, 5'd18, "R11");
    step(16'h0000, 1'b0, 1'b0, 1'b0, 5'd31, "R11");

    // R12: same-cycle load and decision, old flags drive take_o before the edge
    sub_step(16'd5, 16'd5, 5'd12);
    step(16'h0000, 1'b0, 1'b0, 1'b0, 5'd12, "R12");
    sub_step(16'd4, 16'd9, 5'd12);
    step(16'h0000, 1'b0, 1'b0, 1'b0, 5'd10, "R12");

    // signed boundaries: most negative minus one overflows
    sub_step(16'h8000, 16'h0001, 5'd16);
    step(16'h0000, 1'b0, 1'b0, 1'b0, 5'd16, "R10");
    step(16'h0000, 1'b0, 1'b0, 1'b0, 5'd6, "R7");
    sub_step(16'h7FFF, 16'hFFFF, 5'd14);
    for (int cc = 0; cc < 32; cc++)
      step(16'h0000, 1'b0, 1'b0, 1'b0, cc[4:0], tag_of(cc[4:0]));

    // constrained random subtractions and raw flag inputs
    for (int i = 0; i < 600; i++) begin
      logic [DW-1:0] a, b;
      logic [4:0]    cc;
      a  = DW'($urandom);
      cc = 5'($urandom_range(0, 19));
      case ($urandom_range(0, 3))
        0: b = a;
        1: b = a + DW'($urandom_range(0, 2)) - DW'(1);
        default: b = DW'($urandom);
      endcase
      if ($urandom_range(0, 3) == 0)
        step(DW'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), cc, tag_of(cc));
      else if ($urandom_range(0, 4) == 0)
        step(a, 1'($urandom), 1'($urandom), 1'b0, cc, tag_of(cc));
      else
        sub_step(a, b, cc);
    end
    step(16'h0000, 1'b0, 1'b0, 1'b0, 5'd0, "R7");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule